// File: doc/BRIEF.md
# Serial Command Front End for a Digital Potentiometer

This block is the serial slave side of a single 64-position digitally controlled potentiometer. A host selects it by pulling chip select low. It then shifts in, most significant bit first, an identification byte, an instruction byte and, for some commands, a data byte. The block checks the identification byte against a fixed type prefix and the level of an address strap pin. It decodes the instruction and then either returns a value on the serial output or drives single-cycle strobes to the external wiper register and the data-register bank.

All serial inputs are oversampled by the system clock through synchronisers, and edges are found from the synchronised levels. Commands that change state are held until chip select rises after a complete frame. The exception is the increment/decrement command: once it is decoded, every later serial clock pulse produces an immediate wiper step until the host deselects the block. A hold input pauses a transfer without losing its position. Serial output enable is provided as a separate tri-state control.

Top module: `potspi_front`

## Requirements
- R1: The first byte after chip select falls must equal 0101_110 followed by a bit equal to `addr_pin`. On any mismatch, the rest of the frame is ignored until chip select rises, and no strobe follows.
- R2: The second byte carries the opcode in bits 7..4 and a register pointer in bits 3..2. Bits 1..0 must be 00; otherwise the frame is discarded.
- R3: Opcode 1010 followed by a data byte 00+D5..D0 produces one `wcr_wr_stb` pulse with `wr_data` = D after chip select rises.
- R4: Opcode 1100 with pointer P and data D produces one `dr_wr_stb` pulse with `reg_sel` = P and `wr_data` = D after chip select rises.
- R5: Two-byte transfers complete without a data byte. Opcode 1101 gives `wcr_ld_stb` and opcode 1110 gives `dr_save_stb`, each with `reg_sel` = pointer, after chip select rises.
- R6: If chip select rises before a frame is complete, the frame produces no strobe.
- R7: Opcode 1001 returns 00+`wiper_in` and opcode 1011 returns 00+`dreg_rdata` of the pointed register. The value is sent MSB first on `spi_so`, which changes only after falling serial clock edges.
- R8: Opcode 0101 returns seven zero bits followed by `wip_in` in the LSB.
- R9: After opcode 0010, each serial clock rising edge gives one `step_stb` pulse with `step_up` equal to the serial input at that edge. No steps occur after chip select rises.
- R10: `spi_so_oe` is low while chip select is high and while a hold pause is in effect, and high during an active selected frame.
- R11: Hold taken low while the serial clock is low freezes the frame; clock pulses during the pause are ignored. Hold returned high while the clock is low resumes the frame with no loss of bits.
- R12: After reset, no frame is accepted until a high-to-low transition of chip select has been observed.
- R13: An opcode outside the eight defined codes produces no strobe and no read data, whatever bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| addr_pin | input | 1 | Address strap compared to ID bit 0 |
| wip_in | input | 1 | Storage write-in-progress flag |
| wiper_in | input | DW | Current wiper register value |
| dreg_rdata | input | DW | Data register selected by `reg_sel` |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Serial output driver enable |
| reg_sel | output | 2 | Register pointer from the instruction |
| wr_data | output | DW | Data byte payload for writes |
| wcr_wr_stb | output | 1 | Load wiper from `wr_data` |
| wcr_ld_stb | output | 1 | Load wiper from pointed data register |
| dr_wr_stb | output | 1 | Store `wr_data` into pointed data register |
| dr_save_stb | output | 1 | Store wiper into pointed data register |
| step_stb | output | 1 | One wiper step |
| step_up | output | 1 | Step direction, 1 = up |

## Verification
A serial clock pulse can arrive in the same cycle that a hold pause is in force, in the middle of a byte. The frame must then drop that pulse rather than shift it. The bench provokes this by pausing both a wiper write and a wiper read after three data bits and pulsing the clock twice with the input held high. The committed write data and the eight read bits must equal the values sent without a pause, and the output enable must read low during the pause.

// File: rtl/potspi_pkg.sv
// Shared constants and types for the potentiometer serial front end.
// Assumes the frame layout: ID byte, instruction byte, optional data byte.
package potspi_pkg;

    localparam int         BYTE_W    = 8;
    localparam logic [6:0] ID_PREFIX = 7'b0101_110;

    localparam logic [3:0] OP_RD_WCR = 4'b1001;
    localparam logic [3:0] OP_WR_WCR = 4'b1010;
    localparam logic [3:0] OP_RD_DR  = 4'b1011;
    localparam logic [3:0] OP_WR_DR  = 4'b1100;
    localparam logic [3:0] OP_DR2W   = 4'b1101;
    localparam logic [3:0] OP_W2DR   = 4'b1110;
    localparam logic [3:0] OP_STEP   = 4'b0010;
    localparam logic [3:0] OP_STAT   = 4'b0101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INS,
        ST_DATA,
        ST_STEP,
        ST_DONE,
        ST_SKIP
    } fr_state_t;

endpackage

// File: rtl/potspi_sync.sv
// Multi-stage synchroniser for W asynchronous inputs plus edge detection
// on the lowest NE of them. Assumes inputs are slow relative to clk.
module potspi_sync #(
    parameter int              W       = 4,
    parameter int              NE      = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d_in,
    output logic [W-1:0]  lvl,
    output logic [NE-1:0] rise,
    output logic [NE-1:0] fall
);

    logic [W-1:0]  stg [STAGES];
    logic [NE-1:0] prv;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin : p_chain
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl = stg[STAGES-1];

    // Remember the previous synchronised level of the edge-tracked bits.
    always_ff @(posedge clk) begin : p_prev
        if (!rst_n) prv <= RST_VAL[NE-1:0];
        else        prv <= lvl[NE-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < NE; g++) begin : g_edge
            assign rise[g] =  lvl[g] & ~prv[g];
            assign fall[g] = ~lvl[g] &  prv[g];
        end
    endgenerate

endmodule

// File: rtl/potspi_frame.sv
// Frame decoder: checks the ID byte, decodes the instruction, captures the
// data byte, tracks the hold pause and issues the command strobes.
// Assumes synchronised levels and one-cycle edge pulses at its inputs.
module potspi_frame
    import potspi_pkg::*;
#(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_lvl,
    input  logic          si_lvl,
    input  logic          hold_lvl,
    input  logic          cs_lvl,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          addr_pin,
    input  logic          wip_in,
    input  logic [DW-1:0] wiper_in,
    input  logic [DW-1:0] dreg_rdata,
    output logic          frozen,
    output logic          active,
    output logic          tx_phase,
    output logic          tx_first,
    output logic [BYTE_W-1:0] rd_word,
    output logic [1:0]    reg_sel,
    output logic [DW-1:0] wr_data,
    output logic          wcr_wr_stb,
    output logic          wcr_ld_stb,
    output logic          dr_wr_stb,
    output logic          dr_save_stb,
    output logic          step_stb,
    output logic          step_up
);

    localparam int CNT_W = $clog2(BYTE_W);

    fr_state_t         st;
    fr_state_t         nxt_st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sh;
    logic [3:0]        cmd;
    logic [BYTE_W-1:0] byte_in;
    logic              adv;
    logic              shifting;
    logic              is_read;
    logic              last_bit;

    assign byte_in  = {sh, si_lvl};
    assign adv      = sck_rise && !frozen && !cs_lvl && !cs_fall && !cs_rise;
    assign shifting = (st == ST_ID) || (st == ST_INS) || (st == ST_DATA);
    assign last_bit = (cnt == CNT_W'(BYTE_W - 1));
    assign is_read  = (cmd == OP_RD_WCR) || (cmd == OP_RD_DR) || (cmd == OP_STAT);
    assign active   = (st != ST_IDLE);
    assign tx_phase = (st == ST_DATA) && is_read;
    assign tx_first = (cnt == '0);

    // Select the value a read command returns.
    always_comb begin : p_rdsel
        case (cmd)
            OP_RD_WCR: rd_word = BYTE_W'(wiper_in);
            OP_RD_DR:  rd_word = BYTE_W'(dreg_rdata);
            OP_STAT:   rd_word = BYTE_W'(wip_in);
            default:   rd_word = '0;
        endcase
    end

    // Work out the state that follows a completed byte.
    always_comb begin : p_next
        nxt_st = st;
        case (st)
            ST_ID: begin
                if ((byte_in[7:1] == ID_PREFIX) && (byte_in[0] == addr_pin)) nxt_st = ST_INS;
                else                                                          nxt_st = ST_SKIP;
            end
            ST_INS: begin
                if (byte_in[1:0] != 2'b00) begin
                    nxt_st = ST_SKIP;
                end else begin
                    case (byte_in[7:4])
                        OP_RD_WCR, OP_RD_DR, OP_STAT,
                        OP_WR_WCR, OP_WR_DR:        nxt_st = ST_DATA;
                        OP_DR2W, OP_W2DR:           nxt_st = ST_DONE;
                        OP_STEP:                    nxt_st = ST_STEP;
                        default:                    nxt_st = ST_SKIP;
                    endcase
                end
            end
            ST_DATA: nxt_st = ST_DONE;
            default: nxt_st = st;
        endcase
    end

    // Track the hold pause: hold level only counts while the clock is low.
    always_ff @(posedge clk) begin : p_hold
        if (!rst_n)                        frozen <= 1'b0;
        else if ((st == ST_IDLE) || cs_rise) frozen <= 1'b0;
        else if (!sck_lvl)                 frozen <= !hold_lvl;
    end

    // Main frame sequencer: shifting, decode, commit and step strobes.
    always_ff @(posedge clk) begin : p_frame
        if (!rst_n) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            sh          <= '0;
            cmd         <= '0;
            reg_sel     <= '0;
            wr_data     <= '0;
            wcr_wr_stb  <= 1'b0;
            wcr_ld_stb  <= 1'b0;
            dr_wr_stb   <= 1'b0;
            dr_save_stb <= 1'b0;
            step_stb    <= 1'b0;
            step_up     <= 1'b0;
        end else begin
            wcr_wr_stb  <= 1'b0;
            wcr_ld_stb  <= 1'b0;
            dr_wr_stb   <= 1'b0;
            dr_save_stb <= 1'b0;
            step_stb    <= 1'b0;
            if (cs_fall) begin
                st  <= ST_ID;
                cnt <= '0;
                sh  <= '0;
            end else if (cs_rise) begin
                if (st == ST_DONE) begin
                    case (cmd)
                        OP_WR_WCR: wcr_wr_stb  <= 1'b1;
                        OP_WR_DR:  dr_wr_stb   <= 1'b1;
                        OP_DR2W:   wcr_ld_stb  <= 1'b1;
                        OP_W2DR:   dr_save_stb <= 1'b1;
                        default:   ;
                    endcase
                end
                st  <= ST_IDLE;
                cnt <= '0;
            end else if (adv) begin
                if (st == ST_STEP) begin
                    step_stb <= 1'b1;
                    step_up  <= si_lvl;
                end else if (shifting) begin
                    sh  <= byte_in[BYTE_W-2:0];
                    cnt <= cnt + 1'b1;
                    if (last_bit) begin
                        st <= nxt_st;
                        if (st == ST_INS) begin
                            cmd     <= byte_in[7:4];
                            reg_sel <= byte_in[3:2];
                        end
                        if ((st == ST_DATA) && !is_read) wr_data <= byte_in[DW-1:0];
                    end
                end
            end
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wcr_wr_stb, wcr_ld_stb, dr_wr_stb, dr_save_stb, step_stb})); // R3
    AST_COMMIT_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wcr_wr_stb || wcr_ld_stb || dr_wr_stb || dr_save_stb) |-> $past(cs_rise)); // R6
    AST_POINTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wcr_ld_stb || dr_wr_stb || dr_save_stb) |-> $stable(reg_sel)); // R4
    AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && sck_rise && !cs_fall && !cs_rise) |=> ($stable(cnt) && $stable(st) && !step_stb)); // R11

endmodule

// File: rtl/potspi_sout.sv
// Serial output shifter and driver enable. Loads the read word on the
// first falling clock edge of the data byte and shifts on later falls.
// Assumes frame state and pause flag come from the frame decoder.
module potspi_sout
    import potspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              cs_lvl,
    input  logic              cs_fall,
    input  logic              frozen,
    input  logic              active,
    input  logic              tx_phase,
    input  logic              tx_first,
    input  logic [BYTE_W-1:0] rd_word,
    output logic              so_q,
    output logic              so_oe
);

    logic [BYTE_W-2:0] tx_sh;

    // Drive the output enable only for a selected, unpaused frame.
    always_ff @(posedge clk) begin : p_oe
        if (!rst_n) so_oe <= 1'b0;
        else        so_oe <= !cs_lvl && active && !frozen;
    end

    // Shift read data out on falling serial clock edges.
    always_ff @(posedge clk) begin : p_shift
        if (!rst_n) begin
            so_q  <= 1'b0;
            tx_sh <= '0;
        end else if (cs_fall) begin
            so_q  <= 1'b0;
            tx_sh <= '0;
        end else if (sck_fall && !frozen && tx_phase) begin
            if (tx_first) begin
                so_q  <= rd_word[BYTE_W-1];
                tx_sh <= rd_word[BYTE_W-2:0];
            end else begin
                so_q  <= tx_sh[BYTE_W-2];
                tx_sh <= {tx_sh[BYTE_W-3:0], 1'b0};
            end
        end
    end

    AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_fall) |=> $stable(so_q)); // R7
    AST_QUIET_WHEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && $past(frozen)) |-> !so_oe); // R10

endmodule

// File: rtl/potspi_front.sv
// Top level of the potentiometer serial front end. Synchronises the
// serial pins, runs the frame decoder and drives the serial output.
// Assumes the system clock is at least eight times the serial clock.
module potspi_front #(
    parameter int DW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_si,
    input  logic          spi_hold_n,
    input  logic          addr_pin,
    input  logic          wip_in,
    input  logic [DW-1:0] wiper_in,
    input  logic [DW-1:0] dreg_rdata,
    output logic          spi_so,
    output logic          spi_so_oe,
    output logic [1:0]    reg_sel,
    output logic [DW-1:0] wr_data,
    output logic          wcr_wr_stb,
    output logic          wcr_ld_stb,
    output logic          dr_wr_stb,
    output logic          dr_save_stb,
    output logic          step_stb,
    output logic          step_up
);

    import potspi_pkg::*;

    localparam int PIN_W = 4;
    localparam int EDG_W = 2;
    // Bit order {hold_n, si, cs_n, sck}; chip select starts "low" so that
    // only a genuine high-to-low transition opens a frame after reset.
    localparam logic [PIN_W-1:0] PIN_RST = 4'b1000;

    logic [PIN_W-1:0]  pin_lvl;
    logic [EDG_W-1:0]  pin_rise;
    logic [EDG_W-1:0]  pin_fall;
    logic              frozen;
    logic              active;
    logic              tx_phase;
    logic              tx_first;
    logic [BYTE_W-1:0] rd_word;

    potspi_sync #(
        .W       (PIN_W),
        .NE      (EDG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
        .lvl   (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    potspi_frame #(
        .DW (DW)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_rise    (pin_rise[0]),
        .sck_lvl     (pin_lvl[0]),
        .si_lvl      (pin_lvl[2]),
        .hold_lvl    (pin_lvl[3]),
        .cs_lvl      (pin_lvl[1]),
        .cs_fall     (pin_fall[1]),
        .cs_rise     (pin_rise[1]),
        .addr_pin    (addr_pin),
        .wip_in      (wip_in),
        .wiper_in    (wiper_in),
        .dreg_rdata  (dreg_rdata),
        .frozen      (frozen),
        .active      (active),
        .tx_phase    (tx_phase),
        .tx_first    (tx_first),
        .rd_word     (rd_word),
        .reg_sel     (reg_sel),
        .wr_data     (wr_data),
        .wcr_wr_stb  (wcr_wr_stb),
        .wcr_ld_stb  (wcr_ld_stb),
        .dr_wr_stb   (dr_wr_stb),
        .dr_save_stb (dr_save_stb),
        .step_stb    (step_stb),
        .step_up     (step_up)
    );

    potspi_sout u_sout (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_fall (pin_fall[0]),
        .cs_lvl   (pin_lvl[1]),
        .cs_fall  (pin_fall[1]),
        .frozen   (frozen),
        .active   (active),
        .tx_phase (tx_phase),
        .tx_first (tx_first),
        .rd_word  (rd_word),
        .so_q     (spi_so),
        .so_oe    (spi_so_oe)
    );

    AST_DESELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pin_lvl[1] |=> !spi_so_oe); // R10
    AST_NO_STEP_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pin_lvl[1]) |-> !step_stb); // R9

endmodule

// File: tb/potspi_front_test.sv
module potspi_front_test;

    localparam int H = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n  = 1'b0;
    logic       sck    = 1'b0;
    logic       cs_n   = 1'b0;
    logic       si     = 1'b0;
    logic       hold_n = 1'b1;
    logic       a0     = 1'b1;
    logic       wip    = 1'b0;
    logic [5:0] wiper_m = 6'h00;
    logic [5:0] dr_m [4];
    logic [5:0] dreg_rdata;
    logic       so, so_oe, wcr_wr, wcr_ld, dr_wr, dr_save, stp, stp_up;
    logic [1:0] sel;
    logic [5:0] wd;

    assign dreg_rdata = dr_m[sel];

    potspi_front uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_hold_n(hold_n), .addr_pin(a0), .wip_in(wip), .wiper_in(wiper_m),
        .dreg_rdata(dreg_rdata), .spi_so(so), .spi_so_oe(so_oe), .reg_sel(sel),
        .wr_data(wd), .wcr_wr_stb(wcr_wr), .wcr_ld_stb(wcr_ld), .dr_wr_stb(dr_wr),
        .dr_save_stb(dr_save), .step_stb(stp), .step_up(stp_up)
    );

    typedef struct {
        int    kind;
        int    rsel;
        int    val;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    int stray  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int k, input int s, input int v, input string r);
        exp_t e;
        e.kind = k; e.rsel = s; e.val = v; e.req = r;
        sb_q.push_back(e);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input logic [7:0] b, input int hi, input int lo,
                        inout logic [7:0] rx);
        for (int i = hi; i >= lo; i--) begin
            si = b[i];
            wait_n(H);
            rx[i] = so;
            sck = 1'b1;
            wait_n(H);
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] rx);
        logic [7:0] t;
        t = 8'h00;
        bits(b, 7, 0, t);
        rx = t;
    endtask

    task automatic sel_on;
        cs_n = 1'b0;
        wait_n(H);
    endtask

    task automatic sel_off;
        wait_n(H);
        cs_n = 1'b1;
        wait_n(2 * H);
    endtask

    function automatic logic [7:0] id_b(input logic a);
        return {7'b0101_110, a};
    endfunction

    function automatic logic [7:0] ins_b(input logic [3:0] op, input logic [1:0] s);
        return {op, s, 2'b00};
    endfunction

    task automatic frame3(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, output logic [7:0] rx);
        logic [7:0] t;
        sel_on;
        xbyte(b0, t);
        xbyte(b1, t);
        xbyte(b2, rx);
    endtask

    task automatic quiet(input int s0, input string req, input string what);
        check((stray == s0) && (sb_q.size() == 0), req, what, stray - s0, 0);
    endtask

    task automatic drained(input string req);
        check(sb_q.size() == 0, req, "expected strobes missing", sb_q.size(), 0);
    endtask

    // Scoreboard monitor: compare each strobe against the expected queue.
    always @(negedge clk) begin
        int n, k, v, s, ea, eb;
        exp_t e;
        if (rst_n) begin
            n = int'(wcr_wr) + int'(wcr_ld) + int'(dr_wr) + int'(dr_save) + int'(stp);
            if (n != 0) begin
                k = 7; v = 0; s = int'(sel);
                if (n == 1) begin
                    if (wcr_wr)  begin k = 1; v = int'(wd); end
                    if (wcr_ld)  k = 2;
                    if (dr_wr)   begin k = 3; v = int'(wd); end
                    if (dr_save) k = 4;
                    if (stp)     begin k = 5; v = int'(stp_up); end
                end
                if (sb_q.size() == 0) begin
                    stray++;
                    checks++;
                    fails++;
                    $display("FAIL R6 unexpected strobe actual=%0h expected=0", k);
                end else begin
                    e = sb_q.pop_front();
                    if (e.rsel < 0) s = -1;
                    ea = k * 4096 + (s & 255) * 256 + v;
                    eb = e.kind * 4096 + (e.rsel & 255) * 256 + e.val;
                    check(ea == eb, e.req, "strobe", ea, eb);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        int s0;
        dr_m[0] = 6'h01; dr_m[1] = 6'h0C; dr_m[2] = 6'h22; dr_m[3] = 6'h3E;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);

        // Reset state
        check(so_oe == 1'b0, "R10", "oe after reset", so_oe, 0);
        check({wcr_wr, wcr_ld, dr_wr, dr_save, stp} == 5'b0, "R12", "strobes after reset",
              {wcr_wr, wcr_ld, dr_wr, dr_save, stp}, 0);

        // R12: chip select already low at reset, no falling edge seen
        s0 = stray;
        xbyte(id_b(1'b1), rx);
        xbyte(ins_b(4'b1010, 2'd0), rx);
        xbyte(8'h15, rx);
        cs_n = 1'b1;
        wait_n(2 * H);
        quiet(s0, "R12", "frame without CS fall");

        // R3: write wiper
        push(1, -1, 6'h2A, "R3");
        frame3(id_b(1'b1), ins_b(4'b1010, 2'd3), 8'h2A, rx);
        sel_off;
        drained("R3");

        // R4: write data register 2
        push(3, 2, 6'h15, "R4");
        frame3(id_b(1'b1), ins_b(4'b1100, 2'd2), 8'h15, rx);
        sel_off;
        drained("R4");

        // R5: transfers in both directions
        push(2, 1, 0, "R5");
        sel_on; xbyte(id_b(1'b1), rx); xbyte(ins_b(4'b1101, 2'd1), rx); sel_off;
        push(4, 3, 0, "R5");
        sel_on; xbyte(id_b(1'b1), rx); xbyte(ins_b(4'b1110, 2'd3), rx); sel_off;
        drained("R5");

        // R7 / R10: read wiper and data register
        wiper_m = 6'h33;
        frame3(id_b(1'b1), ins_b(4'b1001, 2'd0), 8'h00, rx);
        check(rx == 8'h33, "R7", "read wiper", rx, 8'h33);
        check(so_oe == 1'b1, "R10", "oe while selected", so_oe, 1);
        sel_off;
        check(so_oe == 1'b0, "R10", "oe after deselect", so_oe, 0);
        frame3(id_b(1'b1), ins_b(4'b1011, 2'd1), 8'h00, rx);
        check(rx == 8'h0C, "R7", "read data reg 1", rx, 8'h0C);
        sel_off;

        // R8: status
        wip = 1'b1;
        frame3(id_b(1'b1), ins_b(4'b0101, 2'd0), 8'h00, rx);
        check(rx == 8'h01, "R8", "status busy", rx, 8'h01);
        sel_off;
        wip = 1'b0;
        frame3(id_b(1'b1), ins_b(4'b0101, 2'd0), 8'h00, rx);
        check(rx == 8'h00, "R8", "status idle", rx, 8'h00);
        sel_off;

        // R9: step mode, then no steps once deselected
        push(5, -1, 1, "R9"); push(5, -1, 1, "R9");
        push(5, -1, 0, "R9"); push(5, -1, 1, "R9");
        sel_on;
        xbyte(id_b(1'b1), rx);
        xbyte(ins_b(4'b0010, 2'd0), rx);
        rx = 8'h00;
        bits(8'b1101_0000, 7, 4, rx);
        sel_off;
        drained("R9");
        s0 = stray;
        si = 1'b1; wait_n(H); sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(2 * H);
        quiet(s0, "R9", "pulse after deselect");

        // R1: wrong type field, then wrong address bit
        s0 = stray;
        frame3(8'h4C | {7'b0, a0}, ins_b(4'b1010, 2'd0), 8'h11, rx);
        sel_off;
        quiet(s0, "R1", "bad type field");
        frame3(id_b(1'b0), ins_b(4'b1010, 2'd0), 8'h11, rx);
        sel_off;
        quiet(s0, "R1", "address bit mismatch");
        a0 = 1'b0;
        push(1, -1, 6'h11, "R1");
        frame3(id_b(1'b0), ins_b(4'b1010, 2'd0), 8'h11, rx);
        sel_off;
        drained("R1");
        a0 = 1'b1;

        // R2: nonzero low instruction bits
        s0 = stray;
        frame3(id_b(1'b1), 8'b1010_0001, 8'h07, rx);
        sel_off;
        quiet(s0, "R2", "low bits set");

        // R13: undefined opcode
        frame3(id_b(1'b1), ins_b(4'b0000, 2'd0), 8'hFF, rx);
        check(rx == 8'h00, "R13", "no read data", rx, 0);
        sel_off;
        quiet(s0, "R13", "undefined opcode");

        // R6: partial write frame
        sel_on;
        xbyte(id_b(1'b1), rx);
        xbyte(ins_b(4'b1100, 2'd1), rx);
        rx = 8'h00;
        bits(8'h2F, 7, 3, rx);
        sel_off;
        quiet(s0, "R6", "partial frame");

        // R11: pause in a write data byte with ignored pulses
        push(1, -1, 6'h25, "R11");
        sel_on;
        xbyte(id_b(1'b1), rx);
        xbyte(ins_b(4'b1010, 2'd0), rx);
        rx = 8'h00;
        bits(8'h25, 7, 5, rx);
        hold_n = 1'b0; wait_n(H);
        si = 1'b1;
        for (int p = 0; p < 2; p++) begin
            sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
        end
        hold_n = 1'b1; wait_n(H);
        bits(8'h25, 4, 0, rx);
        sel_off;
        drained("R11");

        // R11 / R10: pause in a read data byte
        wiper_m = 6'h2D;
        sel_on;
        xbyte(id_b(1'b1), rx);
        xbyte(ins_b(4'b1001, 2'd0), rx);
        rx = 8'h00;
        bits(8'h00, 7, 5, rx);
        hold_n = 1'b0; wait_n(H);
        check(so_oe == 1'b0, "R10", "oe during pause", so_oe, 0);
        si = 1'b1;
        for (int p = 0; p < 2; p++) begin
            sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
        end
        hold_n = 1'b1; wait_n(H);
        check(so_oe == 1'b1, "R11", "oe after resume", so_oe, 1);
        bits(8'h00, 4, 0, rx);
        check(rx == 8'h2D, "R11", "read across pause", rx, 8'h2D);
        sel_off;

        wait_n(2 * H);
        drained("R3");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule